// File: doc/BRIEF.md
# Oversampled Serial Receive Queue

This block recovers characters from an asynchronous serial input line and stores them in a small receive queue that a host drains. The line is sampled on an oversampling tick that a separate rate generator supplies. The tick runs at 16 or 8 times the bit rate, and a mode input chooses which. Each character may carry 7 or 8 data bits, an optional even or odd parity bit, and one or two stop bits. The configuration inputs are changed only while the line is idle.

Every stored entry holds the character together with its own framing and parity error flags. The queue is read first-word-fall-through: the oldest entry is always visible on the read outputs, and a one-cycle pop removes it. The block reports the occupancy count, data-ready, queue-full, a sticky overrun flag and a sticky break flag. It also drives an active-low request-to-send output that tells the far end to pause when the queue is nearly full.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 16 entries in arrival order. `rx_count` reports the occupancy (0 to 16), the oldest entry is shown on the `rd_*` outputs, and a `rd_pop` pulse removes it. A pop while the queue is empty has no effect.
- R2: Data bits are taken least significant bit first, after a start bit. With `char7`=1 there are 7 data bits, which land in `rd_data[6:0]`, and `rd_data[7]` reads 0. With `char7`=0 there are 8 data bits.
- R3: With `par_en`=1 a parity bit follows the data. With `par_odd`=0 the data and parity bits together must hold an even number of ones; with `par_odd`=1 they must hold an odd number. On a mismatch the entry is stored with `rd_perr`=1. With `par_en`=0, `rd_perr` is 0.
- R4: With `two_stop`=1 two stop bits are expected, and with `two_stop`=0 one. If any expected stop bit is sampled low, and the frame is not a break, the entry is stored with `rd_ferr`=1.
- R5: With `os8_mode`=1 one bit period is 8 ticks. With `os8_mode`=0 it is 16 ticks. Each bit is sampled at its middle.
- R6: When a character completes while 16 entries are stored, it is discarded and the stored entries are kept. `overrun` then goes to 1 and stays there until an `ovr_clear` pulse.
- R7: A frame whose data bits, parity bit (if enabled) and first stop bit are all low is a break. It stores no entry, and it sets `brk`, which stays set until a `brk_clear` pulse. The receiver then waits for the line to go high before it looks for a new start bit.
- R8: A low level on the line is accepted as a start bit only if it is still low half a bit period later (tick 8 of 16, or tick 4 of 8). A shorter low pulse stores nothing.
- R9: `data_ready` is 1 exactly when at least one entry is stored. `fifo_full` is 1 exactly when 16 entries are stored.
- R10: `rts_n` is 1 when 14 or more entries are stored, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling tick, one clock wide |
| os8_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| char7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits |
| rx | input | 1 | Serial input line, idles high |
| rd_pop | input | 1 | Remove the oldest entry |
| ovr_clear | input | 1 | Clear the overrun flag |
| brk_clear | input | 1 | Clear the break flag |
| rd_data | output | 8 | Oldest character |
| rd_ferr | output | 1 | Framing error of the oldest entry |
| rd_perr | output | 1 | Parity error of the oldest entry |
| rx_count | output | 5 | Number of stored entries |
| data_ready | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 16 entries |
| overrun | output | 1 | Sticky overrun flag |
| brk | output | 1 | Sticky break flag |
| rts_n | output | 1 | Request to send, active low |

## Verification
A deframer that loses track of its bit position shows up after one character. The popped data, or its error flags, then differ from the frame the bench sent, and the mismatch is seen as soon as that frame and one idle bit have passed. A bad read or write pointer, or a bad occupancy counter, shows up within one queue cycle. The symptoms are characters out of order in the 16-deep fill-and-drain run, a wrong `rx_count`, or `rts_n` and `fifo_full` switching at the wrong occupancy. Break and overrun handling that goes wrong leaves a stray entry, or a flag that does not hold until its clear pulse, and the bench checks for both right after the frame that triggers it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_BRKWAIT
   } rxq_state_e;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              ferr;
      logic              perr;
   } rxq_entry_t;
endpackage

// File: rtl/rxq_deframer.sv
module rxq_deframer
   import rxq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic       os8_mode,
   input  logic       char7,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       two_stop,
   output logic       push,
   output rxq_entry_t push_entry,
   output logic       brk_set
);
   localparam int CNT_W = 4;
   localparam int IDX_W = $clog2(CHAR_W);

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("rxq_deframer: SYNC_STAGES must not exceed 4");
   end

   // input synchronizer; SYNC_STAGES = 0 passes the line straight through
   logic [SYNC_STAGES:0] chain;
   assign chain[0] = rx;
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b1;
         else        chain[i+1] <= chain[i];
      end
   end
   logic rx_s;
   assign rx_s = chain[SYNC_STAGES];

   rxq_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  bidx;
   logic [CHAR_W-1:0] shreg;
   logic              par_bit;
   logic              any_high;
   logic              stop_bad;

   logic [CNT_W-1:0]  os_last, half_last;
   logic [IDX_W-1:0]  last_bit;
   logic              bit_mid;
   logic              perr_calc;

   assign os_last   = os8_mode ? CNT_W'(7) : CNT_W'(15);
   assign half_last = os8_mode ? CNT_W'(3) : CNT_W'(7);
   assign last_bit  = char7 ? IDX_W'(CHAR_W-2) : IDX_W'(CHAR_W-1);
   assign bit_mid   = (cnt == os_last);
   assign perr_calc = par_en && ((^shreg ^ par_bit) != par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         bidx       <= '0;
         shreg      <= '0;
         par_bit    <= 1'b0;
         any_high   <= 1'b0;
         stop_bad   <= 1'b0;
         push       <= 1'b0;
         push_entry <= '0;
         brk_set    <= 1'b0;
      end else begin
         push    <= 1'b0;
         brk_set <= 1'b0;
         if (tick) begin
            case (st)
               ST_IDLE: begin
                  if (!rx_s) begin
                     st  <= ST_START;
                     cnt <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == half_last) begin
                     cnt <= '0;
                     if (!rx_s) begin
                        st       <= ST_DATA;
                        bidx     <= '0;
                        shreg    <= '0;
                        par_bit  <= 1'b0;
                        any_high <= 1'b0;
                        stop_bad <= 1'b0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_DATA: begin
                  if (bit_mid) begin
                     cnt         <= '0;
                     shreg[bidx] <= rx_s;
                     any_high    <= any_high | rx_s;
                     if (bidx == last_bit) st <= par_en ? ST_PAR : ST_STOP1;
                     else                  bidx <= bidx + IDX_W'(1);
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_PAR: begin
                  if (bit_mid) begin
                     cnt      <= '0;
                     par_bit  <= rx_s;
                     any_high <= any_high | rx_s;
                     st       <= ST_STOP1;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_STOP1: begin
                  if (bit_mid) begin
                     cnt <= '0;
                     if (!rx_s && !any_high) begin
                        brk_set <= 1'b1;
                        st      <= ST_BRKWAIT;
                     end else if (two_stop) begin
                        stop_bad <= !rx_s;
                        st       <= ST_STOP2;
                     end else begin
                        push       <= 1'b1;
                        push_entry <= '{data: shreg, ferr: !rx_s, perr: perr_calc};
                        st         <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_STOP2: begin
                  if (bit_mid) begin
                     cnt        <= '0;
                     push       <= 1'b1;
                     push_entry <= '{data: shreg, ferr: stop_bad | !rx_s, perr: perr_calc};
                     st         <= ST_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_BRKWAIT: begin
                  if (rx_s) st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) == ST_START) |-> !$past(rx_s)); // R8
   AST_BRK_EXIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_BRKWAIT && st != ST_BRKWAIT) |-> $past(rx_s)); // R7
   AST_BRK_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      brk_set |=> !push); // R7
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  rxq_entry_t                 push_entry,
   input  logic                       pop,
   output rxq_entry_t                 head,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty,
   output logic                       drop
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("rxq_fifo: DEPTH must be a power of two of at least 2");
   end

   rxq_entry_t    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr, rd;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign wr    = push && !full;
   assign rd    = pop && !empty;
   assign drop  = push && full;
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr) mem[wr_ptr] <= push_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr) wr_ptr <= wr_ptr + AW'(1);
         if (rd) rd_ptr <= rd_ptr + AW'(1);
         count <= count + CW'(wr) - CW'(rd);
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R1
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (count == '0)); // R1
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(rd_ptr))); // R6
endmodule

// File: rtl/rxq_top.sv
module rxq_top
   import rxq_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int RTS_LEVEL   = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick,
   input  logic                       os8_mode,
   input  logic                       char7,
   input  logic                       par_en,
   input  logic                       par_odd,
   input  logic                       two_stop,
   input  logic                       rx,
   input  logic                       rd_pop,
   input  logic                       ovr_clear,
   input  logic                       brk_clear,
   output logic [CHAR_W-1:0]          rd_data,
   output logic                       rd_ferr,
   output logic                       rd_perr,
   output logic [$clog2(DEPTH+1)-1:0] rx_count,
   output logic                       data_ready,
   output logic                       fifo_full,
   output logic                       overrun,
   output logic                       brk,
   output logic                       rts_n
);
   localparam int CW = $clog2(DEPTH+1);

   if (RTS_LEVEL < 1 || RTS_LEVEL > DEPTH) begin : g_bad_rts
      $error("rxq_top: RTS_LEVEL must lie in 1..DEPTH");
   end

   logic       push, brk_set, empty, full, drop;
   rxq_entry_t push_entry, head;

   rxq_deframer #(.SYNC_STAGES(SYNC_STAGES)) u_deframer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx),
      .os8_mode(os8_mode), .char7(char7), .par_en(par_en),
      .par_odd(par_odd), .two_stop(two_stop),
      .push(push), .push_entry(push_entry), .brk_set(brk_set)
   );

   rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
      .pop(rd_pop), .head(head), .count(rx_count),
      .full(full), .empty(empty), .drop(drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
         brk     <= 1'b0;
      end else begin
         if (drop)           overrun <= 1'b1;
         else if (ovr_clear) overrun <= 1'b0;
         if (brk_set)        brk <= 1'b1;
         else if (brk_clear) brk <= 1'b0;
      end
   end

   assign rd_data    = head.data;
   assign rd_ferr    = head.ferr;
   assign rd_perr    = head.perr;
   assign data_ready = !empty;
   assign fifo_full  = full;
   assign rts_n      = (rx_count >= CW'(RTS_LEVEL));

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clear) |=> overrun); // R6
   AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && !brk_clear) |=> brk); // R7
   AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> data_ready); // R9
endmodule

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
   localparam int CLK_PERIOD = 10;
   localparam int TDIV       = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic os8_mode = 1'b0, char7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
   logic rx = 1'b1, rd_pop = 1'b0, ovr_clear = 1'b0, brk_clear = 1'b0;
   logic [7:0] rd_data;
   logic rd_ferr, rd_perr, data_ready, fifo_full, overrun, brk, rts_n;
   logic [4:0] rx_count;
   int checks = 0, errors = 0, tcnt = 0;

   rxq_top u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
      tick <= (tcnt == TDIV-1);
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v, input int clks);
      rx = v;
      repeat (clks) @(negedge clk);
   endtask

   function automatic logic par_of(input logic [7:0] d, input bit c7, input bit podd);
      return (c7 ? ^d[6:0] : ^d) ^ podd;
   endfunction

   task automatic send_char(input logic [7:0] d, input bit c7, input bit pen, input bit podd,
                            input bit two, input bit o8, input bit badp, input bit bads);
      int bt;
      logic p;
      os8_mode = o8; char7 = c7; par_en = pen; par_odd = podd; two_stop = two;
      bt = (o8 ? 8 : 16) * TDIV;
      p  = par_of(d, c7, podd) ^ badp;
      drive_bit(1'b0, bt);
      for (int i = 0; i < (c7 ? 7 : 8); i++) drive_bit(d[i], bt);
      if (pen) drive_bit(p, bt);
      if (two) drive_bit(1'b1, bt);
      drive_bit(!bads, bt);
      drive_bit(1'b1, bt);
   endtask

   task automatic pop1();
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      bit c7, pen, podd, two, o8, badp, bads;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R1 reset count", rx_count, 0);
      chk("R9 reset data_ready", data_ready, 0);
      chk("R9 reset fifo_full", fifo_full, 0);
      chk("R10 reset rts_n", rts_n, 0);
      chk("R6 reset overrun", overrun, 0);
      chk("R7 reset brk", brk, 0);

      // random formats, both oversampling ratios (R2 R3 R4 R5)
      for (int n = 0; n < 50; n++) begin
         d = 8'($urandom);
         c7 = $urandom_range(1); pen = $urandom_range(1); podd = $urandom_range(1);
         two = $urandom_range(1); o8 = $urandom_range(1);
         badp = pen && ($urandom_range(3) == 0);
         bads = ($urandom_range(3) == 0);
         if (bads) d[0] = 1'b1;
         send_char(d, c7, pen, podd, two, o8, badp, bads);
         chk("R1 count after one char", rx_count, 1);
         chk("R9 data_ready", data_ready, 1);
         chk("R2 R5 data", rd_data, c7 ? {1'b0, d[6:0]} : d);
         chk("R3 parity flag", rd_perr, badp);
         chk("R4 framing flag", rd_ferr, bads);
         pop1();
         chk("R1 count after pop", rx_count, 0);
      end

      // pop on empty queue
      pop1();
      chk("R1 pop on empty", rx_count, 0);

      // false starts (R8)
      os8_mode = 1'b0;
      drive_bit(1'b0, 4 * TDIV);
      drive_bit(1'b1, 32 * TDIV);
      chk("R8 short low 16x", rx_count, 0);
      os8_mode = 1'b1;
      drive_bit(1'b0, 2 * TDIV);
      drive_bit(1'b1, 16 * TDIV);
      chk("R8 short low 8x", rx_count, 0);
      chk("R8 no break", brk, 0);

      // fill, RTS threshold, full, overrun (R6 R9 R10)
      for (int k = 0; k < 16; k++) begin
         send_char(8'(k * 13 + 5), 0, 0, 0, 0, 0, 0, 0);
         chk("R1 fill count", rx_count, k + 1);
         chk("R10 rts at level", rts_n, (k + 1) >= 14);
         chk("R9 full flag", fifo_full, (k + 1) == 16);
      end
      send_char(8'hEE, 0, 0, 0, 0, 0, 0, 0);
      chk("R6 count held", rx_count, 16);
      chk("R6 overrun set", overrun, 1);
      for (int k = 0; k < 16; k++) begin
         chk("R6 R1 order kept", rd_data, (k * 13 + 5) & 8'hFF);
         pop1();
         chk("R10 rts while draining", rts_n, (15 - k) >= 14);
      end
      chk("R9 empty again", data_ready, 0);
      chk("R6 overrun sticky", overrun, 1);
      ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0; @(negedge clk);
      chk("R6 overrun cleared", overrun, 0);

      // break (R7)
      send_char(8'h00, 0, 0, 0, 0, 0, 0, 1);
      chk("R7 break set", brk, 1);
      chk("R7 break stores nothing", rx_count, 0);
      os8_mode = 1'b0;
      drive_bit(1'b0, 40 * 16 * TDIV / 10);
      drive_bit(1'b0, 10 * 16 * TDIV);
      drive_bit(1'b1, 2 * 16 * TDIV);
      chk("R7 long low stores nothing", rx_count, 0);
      send_char(8'h5A, 0, 1, 1, 0, 0, 0, 0);
      chk("R7 receive after break", rx_count, 1);
      chk("R7 data after break", rd_data, 8'h5A);
      chk("R3 odd parity ok", rd_perr, 0);
      pop1();
      chk("R7 brk sticky", brk, 1);
      brk_clear = 1'b1; @(negedge clk); brk_clear = 1'b0; @(negedge clk);
      chk("R7 brk cleared", brk, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule